// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations. The system uses a 32-bit virtual address and 4 KiB pages. A requester presents a virtual address, a read/write flag and a valid strobe. In the same cycle the block answers with a hit and the physical address, or with a protection fault, or with neither, which means a miss.

After a miss, the block raises a refill request that carries the missing virtual page number. It holds that request until an external table walker returns a physical page number and a write-protect flag. The block then writes that answer into a slot chosen by its replacement logic. A flush input wipes every translation, for use on a context switch.

Replacement never tracks recency. Empty slots are filled first. When every slot is full, the victim comes from a round-robin pointer or, if a parameter selects it, from a free-running 16-bit LFSR.

Top module: `xlate_buf`

## Requirements
- R1: A lookup that hits returns, combinationally in the same cycle, a physical address made of the entry's physical page number (PPN_W bits) above bits [11:0] of the virtual address. The page number is bits [31:12].
- R2: All ENTRIES slots (a power of two from 32 to 128, default 32) are compared in parallel. A translation held in any slot hits.
- R3: A read or write lookup that finds no valid entry, made outside a flush cycle and with no request outstanding, sets `rf_req` high from the next cycle, with `rf_vpn` equal to that lookup's bits [31:12]. Later misses leave `rf_vpn` unchanged while the request is outstanding.
- R4: `rf_valid` while `rf_req` is high stores {`rf_vpn`, `rf_ppn`, `rf_wprot`} and drops `rf_req` on the next cycle. Lookups of that page hit from the next cycle on.
- R5: `rf_valid` while no request is outstanding is ignored and creates no translation.
- R6: A write that hits an entry with its write-protect flag set gives `lk_fault`=1 and `lk_hit`=0. A read of that entry hits normally. When `lk_hit` is 0, `lk_paddr` is zero.
- R7: A flush invalidates every entry, so later lookups miss until refills arrive. It also cancels an outstanding refill request.
- R8: A lookup made in the same cycle as a flush reports a miss (`lk_hit`=0, `lk_fault`=0) and raises no refill request.
- R9: A refill goes to the lowest-numbered invalid slot whenever one exists.
- R10: In the default round-robin mode, a refill into a full buffer replaces the slot named by a pointer. The pointer starts at 0 after reset, is not changed by a flush, and advances by one modulo ENTRIES on every accepted refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all translations |
| lk_valid | input | 1 | Lookup strobe |
| lk_write | input | 1 | Lookup is a write |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_hit | output | 1 | Translation found and permitted |
| lk_fault | output | 1 | Write to a write-protected page |
| lk_paddr | output | PPN_W+12 | Physical address, zero unless hit |
| rf_req | output | 1 | Refill request outstanding |
| rf_vpn | output | 20 | Page number to be refilled |
| rf_valid | input | 1 | Refill answer strobe |
| rf_ppn | input | PPN_W | Physical page number of the answer |
| rf_wprot | input | 1 | Write-protect flag of the answer |

## Verification
A stale valid bit shows up at the ports on the first lookup of the affected page: a lookup after a flush still hits. A wrong tag or page number shows up the same way, as a wrong physical address. A replacement pointer that is off by one, or that was reset by the flush, stays hidden until the buffer fills. The first eviction after that then removes the wrong page, so the bench fills all slots after an offset flush and checks which single page disappears. A request register that is overwritten or left set shows on `rf_vpn` and `rf_req` one cycle after the offending lookup.

// File: rtl/xb_pkg.sv
package xb_pkg;
    localparam int VA_W  = 32;
    localparam int OFF_W = 12;
    localparam int VPN_W = VA_W - OFF_W;

    typedef enum logic {
        VICT_RROBIN = 1'b0,
        VICT_LFSR   = 1'b1
    } vict_mode_e;
endpackage

// File: rtl/xb_cam.sv
module xb_cam #(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES),
    localparam int TAG_W = xb_pkg::VPN_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ENTRIES-1:0]             ent_vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0]  ent_tag,
    input  logic [TAG_W-1:0]               key,
    output logic [ENTRIES-1:0]             match,
    output logic                           any,
    output logic [IDX_W-1:0]               idx
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_vld[g] && (ent_tag[g] == key);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end

    assign any = |match;

    // R2: refills only store missing pages, so at most one slot matches
    assert_single_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/xb_victim.sv
module xb_victim #(
    parameter int ENTRIES = 32,
    parameter xb_pkg::vict_mode_e MODE = xb_pkg::VICT_RROBIN,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] ent_vld,
    input  logic               fill,
    output logic [IDX_W-1:0]   victim
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic [15:0]      lfsr;
    } vst_t;

    vst_t st_d, st_q;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] full_pick;

    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    if (MODE == xb_pkg::VICT_LFSR) begin : g_lfsr
        assign full_pick = st_q.lfsr[IDX_W-1:0];
    end else begin : g_rr
        assign full_pick = st_q.ptr;
    end

    assign victim = free_any ? free_idx : full_pick;

    always_comb begin
        st_d      = st_q;
        st_d.lfsr = {1'b0, st_q.lfsr[15:1]} ^ (st_q.lfsr[0] ? 16'hB400 : 16'h0000);
        if (fill) st_d.ptr = st_q.ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ptr  <= '0;
            st_q.lfsr <= 16'hACE1;
        end else begin
            st_q <= st_d;
        end
    end

    assert_free_slot_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill && !(&ent_vld)) |-> !ent_vld[victim]);
    assert_ptr_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fill |=> (st_q.ptr == $past(st_q.ptr) + 1'b1));
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf #(
    parameter int ENTRIES = 32,
    parameter int PPN_W   = 20,
    parameter xb_pkg::vict_mode_e MODE = xb_pkg::VICT_RROBIN,
    localparam int VPN_W = xb_pkg::VPN_W,
    localparam int OFF_W = xb_pkg::OFF_W,
    localparam int PA_W  = PPN_W + OFF_W,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      flush,
    input  logic                      lk_valid,
    input  logic                      lk_write,
    input  logic [xb_pkg::VA_W-1:0]   lk_vaddr,
    output logic                      lk_hit,
    output logic                      lk_fault,
    output logic [PA_W-1:0]           lk_paddr,
    output logic                      rf_req,
    output logic [VPN_W-1:0]          rf_vpn,
    input  logic                      rf_valid,
    input  logic [PPN_W-1:0]          rf_ppn,
    input  logic                      rf_wprot
);
    typedef struct packed {
        logic [ENTRIES-1:0]            vld;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [ENTRIES-1:0]            wp;
        logic                          pend;
        logic [VPN_W-1:0]              pvpn;
    } tst_t;

    tst_t st_d, st_q;

    logic [VPN_W-1:0]   key_vpn;
    logic [ENTRIES-1:0] cam_match;
    logic               cam_any;
    logic [IDX_W-1:0]   cam_idx;
    logic [IDX_W-1:0]   victim;
    logic               look_ok;
    logic               sel_wp;
    logic               fill;

    assign key_vpn = lk_vaddr[xb_pkg::VA_W-1:OFF_W];

    xb_cam #(.ENTRIES(ENTRIES)) u_cam (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_vld(st_q.vld),
        .ent_tag(st_q.tag),
        .key    (key_vpn),
        .match  (cam_match),
        .any    (cam_any),
        .idx    (cam_idx)
    );

    assign fill = rf_valid && st_q.pend && !flush;

    xb_victim #(.ENTRIES(ENTRIES), .MODE(MODE)) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_vld(st_q.vld),
        .fill   (fill),
        .victim (victim)
    );

    assign look_ok = lk_valid && !flush;
    assign sel_wp  = st_q.wp[cam_idx];

    always_comb begin
        lk_hit   = look_ok && cam_any && !(lk_write && sel_wp);
        lk_fault = look_ok && cam_any && lk_write && sel_wp;
        lk_paddr = lk_hit ? {st_q.ppn[cam_idx], lk_vaddr[OFF_W-1:0]} : '0;
    end

    assign rf_req = st_q.pend;
    assign rf_vpn = st_q.pvpn;

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.vld  = '0;
            st_d.pend = 1'b0;
        end else begin
            if (fill) begin
                st_d.vld[victim] = 1'b1;
                st_d.tag[victim] = st_q.pvpn;
                st_d.ppn[victim] = rf_ppn;
                st_d.wp[victim]  = rf_wprot;
                st_d.pend        = 1'b0;
            end
            if (look_ok && !cam_any && !st_q.pend) begin
                st_d.pend = 1'b1;
                st_d.pvpn = key_vpn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_offset_passthru_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));
    assert_req_after_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rf_req) |-> $past(lk_valid && !flush && !lk_hit && !lk_fault));
    assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && !rf_valid && !flush) |=> (rf_req && $stable(rf_vpn)));
    assert_refill_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_req && rf_valid && !flush) |=> !rf_req);
    assert_hit_fault_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && lk_fault));
    assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!lk_hit && !lk_fault && !rf_req));
    assert_flush_cycle_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!lk_hit && !lk_fault));
endmodule

// File: tb/xlate_buf_bench.sv
`timescale 1ns/1ps
module xlate_buf_bench;
    localparam int PPN_W = 20;
    localparam int PA_W  = PPN_W + 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0, lk_valid = 1'b0, lk_write = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic lk_hit, lk_fault, rf_req;
    logic [PA_W-1:0] lk_paddr;
    logic [19:0] rf_vpn;
    logic rf_valid = 1'b0, rf_wprot = 1'b0;
    logic [PPN_W-1:0] rf_ppn = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    typedef struct {
        logic hit; logic fault; logic [PA_W-1:0] pa; string req;
    } exp_t;
    exp_t expq[$];

    always #10 clk = ~clk;

    xlate_buf u_xlate_buf (
        .clk(clk), .rst_n(rst_n), .flush(flush), .lk_valid(lk_valid),
        .lk_write(lk_write), .lk_vaddr(lk_vaddr), .lk_hit(lk_hit),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr), .rf_req(rf_req),
        .rf_vpn(rf_vpn), .rf_valid(rf_valid), .rf_ppn(rf_ppn), .rf_wprot(rf_wprot)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per lookup, mid-cycle
    always @(negedge clk) begin
        if (rst_n && lk_valid && expq.size() > 0) begin
            exp_t e;
            e = expq.pop_front();
            chk(lk_hit == e.hit && lk_fault == e.fault && lk_paddr == e.pa, e.req,
                {lk_hit, lk_fault, 30'd0, lk_paddr}, {e.hit, e.fault, 30'd0, e.pa});
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic lookup(input logic [31:0] va, input bit wr, input bit fl,
                          input bit h, input bit f, input logic [PA_W-1:0] pa, input string req);
        exp_t e;
        e.hit = h; e.fault = f; e.pa = pa; e.req = req;
        expq.push_back(e);
        lk_vaddr = va; lk_write = wr; lk_valid = 1'b1; flush = fl;
        tick();
        lk_valid = 1'b0; lk_write = 1'b0; flush = 1'b0;
    endtask

    task automatic refill(input logic [PPN_W-1:0] p, input bit wp);
        rf_ppn = p; rf_wprot = wp; rf_valid = 1'b1;
        tick();
        rf_valid = 1'b0;
    endtask

    // miss, check the request, answer it
    task automatic miss_fill(input logic [19:0] vpn, input logic [PPN_W-1:0] p, input bit wp, input string req);
        lookup({vpn, 12'h000}, 1'b0, 1'b0, 1'b0, 1'b0, '0, req);
        chk(rf_req === 1'b1 && rf_vpn == vpn, "R3", {43'd0, rf_req, rf_vpn}, {43'd0, 1'b1, vpn});
        refill(p, wp);
        chk(rf_req === 1'b0, "R4", 64'(rf_req), 64'd0);
    endtask

    task automatic do_flush();
        flush = 1'b1;
        tick();
        flush = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // reset state
        chk(rf_req === 1'b0 && lk_hit === 1'b0 && lk_fault === 1'b0, "R3 reset",
            {lk_hit, lk_fault, rf_req}, 64'd0);

        // R5: stray refill stores nothing (pending tag would be page 0)
        refill(20'h00055, 1'b0);
        chk(rf_req === 1'b0, "R5", 64'(rf_req), 64'd0);
        miss_fill(20'h00000, 20'h00777, 1'b0, "R5 stray refill ignored");
        lookup(32'h0000_0123, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0077_7123, "R1");

        // R6: write-protect
        miss_fill(20'h12345, 20'hABCDE, 1'b1, "R3");
        lookup(32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b0, 32'hABCD_E678, "R6 read");
        lookup(32'h1234_5678, 1'b1, 1'b0, 1'b0, 1'b1, '0, "R6 write fault");
        lookup(32'h0000_0ABC, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0077_7ABC, "R6 write ok");

        // R3: second miss while pending keeps the first page
        lookup(32'h2222_2000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
        lookup(32'h3333_3000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
        chk(rf_req === 1'b1 && rf_vpn == 20'h22222, "R3 held", 64'(rf_vpn), 64'h22222);
        refill(20'h00042, 1'b0);
        lookup(32'h2222_2FFF, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0004_2FFF, "R4");
        lookup(32'h3333_3000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R3");
        // R8: lookup in flush cycle misses; R7 cancels the request
        lookup(32'h2222_2000, 1'b0, 1'b1, 1'b0, 1'b0, '0, "R8");
        chk(rf_req === 1'b0, "R7 R8 request dropped", 64'(rf_req), 64'd0);
        lookup(32'h1234_5000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7");
        lookup(32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R7");
        refill(20'h00099, 1'b0);    // fourth accepted refill: pointer now 4
        do_flush();

        // R9: fill all slots after flush; free slots first
        for (int i = 0; i < 32; i++) miss_fill(20'h40000 + 20'(i), 20'h00100 + 20'(i), 1'b0, "R9");
        for (int i = 0; i < 32; i++)
            lookup({20'h40000 + 20'(i), 12'h010}, 1'b0, 1'b0, 1'b1, 1'b0,
                   {20'h00100 + 20'(i), 12'h010}, "R2");
        // R10: full, pointer at 4 evicts the fifth page filled
        miss_fill(20'h50000, 20'h00500, 1'b0, "R10");
        lookup(32'h5000_0001, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0050_0001, "R10 new");
        lookup(32'h4000_0001, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0010_0001, "R9 R10 first kept");
        lookup(32'h4000_3001, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0010_3001, "R10");
        lookup(32'h4000_5001, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0010_5001, "R10");
        lookup(32'h4000_4001, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 evicted");
        refill(20'h00321, 1'b0);
        lookup(32'h4000_4002, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0032_1002, "R4");
        lookup(32'h4000_5002, 1'b0, 1'b0, 1'b0, 1'b0, '0, "R10 advanced");

        tick();
        chk(expq.size() == 0, "R1 monitor drained", 64'(expq.size()), 64'd0);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule